// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block gathers sixteen interrupt request lines, one per priority slot, and turns the most urgent deliverable request into a 16-bit handler address. Slot 15 is the highest priority and slot 0 the lowest. Slot s maps to address `16'hFFE0 + 2*s`, so slot 15 resolves to `16'hFFFE` and slot 0 to `16'hFFE0`. Slot 15 is the reset slot and cannot be blocked. Slot 14 is the non-maskable class: its own enable bit gates it, and the global enable does not. Slots 0 to 13 need both their own enable bit and the global enable.

Some slots represent single event sources. A one-cycle pulse on such a line is latched into a flag held in this block. Other slots stand for several sources that are ORed upstream, and their flags stay in the originating modules. For those slots the request line is taken as a level and nothing is stored here. An acknowledge input tells the block that the vector currently shown has been taken. The acknowledge clears the latched flag of that slot and drops the global enable, unless the slot is the non-maskable one. A byte-wide register port gives software access to the enable bits, the flags and the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every enable bit and the global enable are 0, no vector is valid, and every flag is 0 except the latched flags of slot 8 and slot 14, which read as 1.
- R2: A valid vector for slot s carries address 16'hFFE0 + 2*s on `vec_addr_o` and s on `vec_slot_o`. When no vector is valid, both outputs are 0.
- R3: A request on slot 15 is delivered whatever the enable bits and the global enable hold, and it wins over every other slot.
- R4: Slot 14 is delivered when its enable bit is 1, even with the global enable clear. It is not delivered when its enable bit is 0.
- R5: Slots 0 to 13 are delivered only when their enable bit and the global enable are both 1.
- R6: When several slots are deliverable together, the highest-numbered one is shown.
- R7: The vector outputs are registered. They reflect the requests, register writes and acknowledge of the previous clock cycle.
- R8: On the single-source slots (0, 2, 6, 8, 9, 10, 11, 13, 14) a one-cycle request pulse sets a flag that stays set. On the multi-source slots (1, 3, 4, 5, 7, 12, 15) the request is used as a live level and nothing is latched.
- R9: An acknowledge while a vector is valid clears the latched flag of the shown slot. An acknowledge while no vector is valid changes nothing.
- R10: An acknowledge of a valid vector clears the global enable unless the shown slot is 14, and this takes precedence over a write to the global enable in the same cycle.
- R11: The register map is as follows. Address 0 holds enables 7..0 and address 1 holds enables 15..8. Address 2 holds flags 7..0 and address 3 holds flags 15..8. Address 4 bit 0 holds the global enable. Other addresses read 0. A flag byte write sets or clears the single-source flags. The multi-source bits of a flag byte read the live request and ignore writes. If a request pulse and a flag write land on the same cycle, the pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request line per slot |
| ack_i | input | 1 | Acknowledge of the vector currently shown |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| vec_valid_o | output | 1 | A deliverable vector is shown |
| vec_slot_o | output | 4 | Slot number of the shown vector |
| vec_addr_o | output | 16 | Handler address of the shown vector |

## Verification
The bench pulses two enabled maskable slots in the same cycle. A reversed or truncated priority encoder would show the lower slot. The bench makes slot 14 fire from its reset-set flag while the global enable is still clear, and it acknowledges that slot. A design that let the global enable gate slot 14, or that dropped the global enable on its acknowledge, would lose the interrupt or later mask the maskable ones. It holds a multi-source level while writing every flag bit. A design that latched multi-source requests, or let writes reach them, would keep showing slot 12 after the level drops or would read back the wrong byte. It also raises slot 15 with everything disabled and checks the end-of-table addresses. A wrong base or step would show up at FFE0 and FFFE.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int BYTE_W = 8;

    // Handler address for a slot: base plus two bytes per slot.
    function automatic logic [15:0] ivc_vec_addr(input logic [15:0] base, input logic [3:0] slot);
        return base + {11'd0, slot, 1'b0};
    endfunction

endpackage

// File: rtl/ivc_state_next.sv
module ivc_state_next #(
    parameter int NSLOT  = 16,
    parameter int SLOT_W = 4,
    parameter int NBYTE  = 2,
    parameter int ADDR_W = 3
) (
    input  logic [NSLOT-1:0]  en_q,
    input  logic [NSLOT-1:0]  flag_q,
    input  logic              gie_q,
    input  logic [NSLOT-1:0]  set_i,
    input  logic              ack_i,
    input  logic              vld_q,
    input  logic [SLOT_W-1:0] slot_q,
    input  logic              nmi_shown_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [NSLOT-1:0]  en_n,
    output logic [NSLOT-1:0]  flag_n,
    output logic              gie_n
);
    localparam int CTRL_ADDR = 2 * NBYTE;

    logic ack_take;
    assign ack_take = ack_i && vld_q;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam int LANE = i / 8;
        localparam int BITP = i % 8;
        logic hit_en, hit_fl, ack_me;
        assign hit_en = wr_en_i && (wr_addr_i == ADDR_W'(LANE));
        assign hit_fl = wr_en_i && (wr_addr_i == ADDR_W'(NBYTE + LANE));
        assign ack_me = ack_take && (slot_q == SLOT_W'(i));
        assign en_n[i]   = hit_en ? wr_data_i[BITP] : en_q[i];
        // Request pulse beats both the acknowledge clear and a software write.
        assign flag_n[i] = set_i[i] | (~ack_me & (hit_fl ? wr_data_i[BITP] : flag_q[i]));
    end

    always_comb begin
        gie_n = gie_q;
        if (wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR))) begin
            gie_n = wr_data_i[0];
        end
        if (ack_take && !nmi_shown_i) begin
            gie_n = 1'b0;
        end
    end

endmodule

// File: rtl/ivc_elig.sv
module ivc_elig #(
    parameter int NSLOT = 16
) (
    input  logic [NSLOT-1:0] pend_i,
    input  logic [NSLOT-1:0] en_i,
    input  logic             gie_i,
    output logic [NSLOT-1:0] elig_o
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_gate
        if (i == NSLOT - 1) begin : g_reset
            assign elig_o[i] = pend_i[i];
        end else if (i == NSLOT - 2) begin : g_nmi
            assign elig_o[i] = pend_i[i] & en_i[i];
        end else begin : g_mask
            assign elig_o[i] = pend_i[i] & en_i[i] & gie_i;
        end
    end

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int NSLOT  = 16,
    parameter int SLOT_W = 4
) (
    input  logic [NSLOT-1:0]  elig_i,
    output logic              found_o,
    output logic [SLOT_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (elig_i[i]) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_rd_mux.sv
module ivc_rd_mux #(
    parameter int NSLOT  = 16,
    parameter int NBYTE  = 2,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [NSLOT-1:0]  en_i,
    input  logic [NSLOT-1:0]  view_i,
    input  logic              gie_i,
    output logic [7:0]        rd_data_o
);
    always_comb begin
        rd_data_o = '0;
        for (int b = 0; b < NBYTE; b++) begin
            if (rd_addr_i == ADDR_W'(b)) begin
                rd_data_o = en_i[b*8 +: 8];
            end
            if (rd_addr_i == ADDR_W'(NBYTE + b)) begin
                rd_data_o = view_i[b*8 +: 8];
            end
        end
        if (rd_addr_i == ADDR_W'(2 * NBYTE)) begin
            rd_data_o = {7'd0, gie_i};
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int               NSLOT      = 16,
    parameter int               VEC_W      = 16,
    parameter logic [VEC_W-1:0] VEC_BASE   = 16'hFFE0,
    parameter logic [NSLOT-1:0] MULTI_MASK = 16'h90BA,
    parameter logic [NSLOT-1:0] FLAG_INIT  = 16'h4100,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int NBYTE  = NSLOT / 8,
    localparam int ADDR_W = $clog2(2 * NBYTE + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSLOT-1:0]  irq_i,
    input  logic              ack_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              vec_valid_o,
    output logic [SLOT_W-1:0] vec_slot_o,
    output logic [VEC_W-1:0]  vec_addr_o
);
    import ivc_pkg::*;

    localparam int RST_SLOT = NSLOT - 1;
    localparam int NMI_SLOT = NSLOT - 2;

    typedef struct packed {
        logic [NSLOT-1:0]  en;
        logic [NSLOT-1:0]  flag;
        logic              gie;
        logic              vld;
        logic [SLOT_W-1:0] slot;
        logic [VEC_W-1:0]  addr;
    } ivc_state_t;

    ivc_state_t st_d, st_q;

    logic [NSLOT-1:0] en_n, flag_n, flag_keep, pend, elig, view;
    logic             gie_n, found, nmi_shown;
    logic [SLOT_W-1:0] idx;

    assign nmi_shown = (st_q.slot == SLOT_W'(NMI_SLOT));

    ivc_state_next #(
        .NSLOT(NSLOT), .SLOT_W(SLOT_W), .NBYTE(NBYTE), .ADDR_W(ADDR_W)
    ) u_next (
        .en_q        (st_q.en),
        .flag_q      (st_q.flag),
        .gie_q       (st_q.gie),
        .set_i       (irq_i & ~MULTI_MASK),
        .ack_i       (ack_i),
        .vld_q       (st_q.vld),
        .slot_q      (st_q.slot),
        .nmi_shown_i (nmi_shown),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .en_n        (en_n),
        .flag_n      (flag_n),
        .gie_n       (gie_n)
    );

    // Multi-source slots keep no flag here; their line is taken live.
    assign flag_keep = flag_n & ~MULTI_MASK;
    assign pend      = (irq_i & MULTI_MASK) | flag_keep;

    ivc_elig #(.NSLOT(NSLOT)) u_elig (
        .pend_i (pend),
        .en_i   (en_n),
        .gie_i  (gie_n),
        .elig_o (elig)
    );

    ivc_prio_enc #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_prio (
        .elig_i  (elig),
        .found_o (found),
        .idx_o   (idx)
    );

    assign view = (irq_i & MULTI_MASK) | st_q.flag;

    ivc_rd_mux #(.NSLOT(NSLOT), .NBYTE(NBYTE), .ADDR_W(ADDR_W)) u_rd (
        .rd_addr_i (rd_addr_i),
        .en_i      (st_q.en),
        .view_i    (view),
        .gie_i     (st_q.gie),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.en   = en_n;
        st_d.flag = flag_keep;
        st_d.gie  = gie_n;
        st_d.vld  = found;
        st_d.slot = found ? idx : '0;
        st_d.addr = found ? VEC_W'(ivc_vec_addr(16'(VEC_BASE), 4'(idx))) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{en: '0, flag: (FLAG_INIT & ~MULTI_MASK), gie: 1'b0,
                      vld: 1'b0, slot: '0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_valid_o = st_q.vld;
    assign vec_slot_o  = st_q.slot;
    assign vec_addr_o  = st_q.addr;

    AST_RESET_SLOT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i[RST_SLOT] |=> (vec_valid_o && vec_slot_o == SLOT_W'(RST_SLOT))); // R3
    AST_NMI_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && vec_slot_o == SLOT_W'(NMI_SLOT)) |-> st_q.en[NMI_SLOT]); // R4
    AST_MASKABLE_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && vec_slot_o < SLOT_W'(NMI_SLOT)) |-> (st_q.gie && st_q.en[vec_slot_o])); // R5
    AST_ADDR_IN_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> (vec_addr_o >= VEC_BASE && !vec_addr_o[0])); // R2
    AST_ACK_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && vec_valid_o && vec_slot_o != SLOT_W'(NMI_SLOT)) |=> !st_q.gie); // R10
    AST_NMI_ACK_KEEPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && vec_valid_o && vec_slot_o == SLOT_W'(NMI_SLOT) && !wr_en_i)
        |=> (st_q.gie == $past(st_q.gie))); // R10

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        ack = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  wa = '0;
    logic [7:0]  wd = '0;
    logic [2:0]  ra = '0;
    logic [7:0]  rd;
    logic        vvld;
    logic [3:0]  vslot;
    logic [15:0] vaddr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ack_i(ack),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra),
        .rd_data_o(rd), .vec_valid_o(vvld), .vec_slot_o(vslot), .vec_addr_o(vaddr)
    );

    // Behavioural reference state
    bit        m_en[16];
    bit        m_fl[16];
    bit        m_gie;
    bit        m_vld;
    int        m_slot;
    int        m_addr;
    localparam logic [15:0] MULTI = 16'h90BA;

    function automatic logic [7:0] m_read(input int a, input logic [15:0] lv);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            if (a == 0) r[k] = m_en[k];
            if (a == 1) r[k] = m_en[8 + k];
            if (a == 2) r[k] = MULTI[k] ? lv[k] : m_fl[k];
            if (a == 3) r[k] = MULTI[8 + k] ? lv[8 + k] : m_fl[8 + k];
        end
        if (a == 4) r = {7'd0, m_gie};
        return r;
    endfunction

    task automatic m_step();
        bit nen[16];
        bit nfl[16];
        bit ngie = m_gie;
        int best = -1;
        for (int i = 0; i < 16; i++) begin
            nen[i] = m_en[i];
            nfl[i] = m_fl[i];
            if (we && wa == 3'(i / 8)) nen[i] = wd[i % 8];
            if (!MULTI[i]) begin
                if (we && wa == 3'(2 + i / 8)) nfl[i] = wd[i % 8];
                if (ack && m_vld && m_slot == i) nfl[i] = 1'b0;
                if (irq[i]) nfl[i] = 1'b1;
            end else begin
                nfl[i] = 1'b0;
            end
        end
        if (we && wa == 3'd4) ngie = wd[0];
        if (ack && m_vld && m_slot != 14) ngie = 1'b0;
        for (int i = 0; i < 16; i++) begin
            bit p = MULTI[i] ? irq[i] : nfl[i];
            bit ok;
            if (i == 15) ok = p;
            else if (i == 14) ok = p && nen[i];
            else ok = p && nen[i] && ngie;
            if (ok) best = i;
        end
        for (int i = 0; i < 16; i++) begin
            m_en[i] = nen[i];
            m_fl[i] = nfl[i];
        end
        m_gie  = ngie;
        m_vld  = (best >= 0);
        m_slot = (best >= 0) ? best : 0;
        m_addr = (best >= 0) ? 16'hFFE0 + 2 * best : 0;
    endtask

    task automatic compare(input string tag);
        logic [7:0] er = m_read(int'(ra), irq);
        total++;
        if (vvld !== m_vld || int'(vslot) != m_slot || int'(vaddr) != m_addr) begin
            bad++;
            $display("FAIL %s: vector actual v=%0b slot=%0d addr=%h expected v=%0b slot=%0d addr=%h",
                     tag, vvld, vslot, vaddr, m_vld, m_slot, m_addr[15:0]);
        end
        total++;
        if (rd !== er) begin
            bad++;
            $display("FAIL %s: read addr %0d actual %h expected %h", tag, ra, rd, er);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then check after the next falling edge.
    task automatic tick(input logic [15:0] i_irq, input bit i_ack, input bit i_we,
                        input logic [2:0] i_wa, input logic [7:0] i_wd,
                        input logic [2:0] i_ra, input string tag);
        irq = i_irq; ack = i_ack; we = i_we; wa = i_wa; wd = i_wd; ra = i_ra;
        m_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input logic [15:0] lv, input logic [2:0] r, input string tag);
        tick(lv, 0, 0, 3'd0, 8'h00, r, tag);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d, input logic [15:0] lv, input string tag);
        tick(lv, 0, 1, a, d, a, tag);
    endtask

    task automatic do_ack(input logic [15:0] lv, input string tag);
        tick(lv, 1, 0, 3'd0, 8'h00, 3'd4, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_en[i] = 0;
            m_fl[i] = (i == 8 || i == 14);
        end
        m_gie = 0; m_vld = 0; m_slot = 0; m_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        // R1: reset contents of every register
        for (int a = 0; a < 6; a++) idle(16'h0, 3'(a), "R1");

        // R4: slot 14 flag set from reset fires once its enable is set, global enable clear
        wreg(3'd1, 8'h40, 16'h0, "R4");
        idle(16'h0, 3'd3, "R4");
        // R9 R10: ack of slot 14 clears its flag, global enable untouched
        do_ack(16'h0, "R9");
        idle(16'h0, 3'd3, "R10");
        // R9: ack with nothing shown changes nothing
        do_ack(16'h0, "R9");

        // R5: maskable slot latched but held back while global enable clear
        wreg(3'd0, 8'h40, 16'h0, "R5");
        tick(16'h0040, 0, 0, 3'd0, 8'h00, 3'd2, "R8");
        idle(16'h0, 3'd2, "R5");
        wreg(3'd4, 8'h01, 16'h0, "R2");
        idle(16'h0, 3'd4, "R2");

        // R6: two pulses in one cycle, highest wins
        wreg(3'd1, 8'h02, 16'h0, "R6");
        wreg(3'd0, 8'h44, 16'h0, "R6");
        tick(16'h0204, 0, 0, 3'd0, 8'h00, 3'd3, "R6");
        do_ack(16'h0, "R10");
        wreg(3'd4, 8'h01, 16'h0, "R6");
        do_ack(16'h0, "R10");
        // R10: ack beats a same-cycle global enable write
        tick(16'h0, 1, 1, 3'd4, 8'h01, 3'd4, "R10");
        wreg(3'd4, 8'h01, 16'h0, "R6");
        do_ack(16'h0, "R9");
        wreg(3'd4, 8'h01, 16'h0, "R7");

        // R8 R11: multi-source level, flag byte writes
        wreg(3'd1, 8'h12, 16'h1000, "R8");
        idle(16'h1000, 3'd3, "R8");
        wreg(3'd3, 8'hFF, 16'h1000, "R11");
        idle(16'h1000, 3'd3, "R11");
        idle(16'h0000, 3'd3, "R8");
        do_ack(16'h0, "R9");
        wreg(3'd3, 8'h00, 16'h0, "R11");
        wreg(3'd2, 8'hFF, 16'h0, "R11");
        idle(16'h0, 3'd2, "R11");
        wreg(3'd2, 8'h00, 16'h0, "R11");
        idle(16'h0, 3'd6, "R11");

        // R3: reset slot with every gate closed
        wreg(3'd0, 8'h00, 16'h0, "R3");
        wreg(3'd1, 8'h00, 16'h0, "R3");
        wreg(3'd4, 8'h00, 16'h8000, "R3");
        tick(16'hC044, 0, 0, 3'd0, 8'h00, 3'd3, "R3");
        do_ack(16'h8000, "R3");
        idle(16'h0, 3'd4, "R3");

        // R2 R7: lowest slot address and one-cycle latency
        wreg(3'd0, 8'h01, 16'h0, "R2");
        wreg(3'd4, 8'h01, 16'h0, "R2");
        wreg(3'd2, 8'h00, 16'h0, "R2");
        tick(16'h0001, 0, 0, 3'd0, 8'h00, 3'd2, "R7");
        idle(16'h0, 3'd2, "R2");
        do_ack(16'h0, "R9");
        idle(16'h0, 3'd4, "R10");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule